// File: doc/BRIEF.md
# Multiframe Phase Generator with SYSREF Re-alignment

This block keeps the local multiframe phase for a multi-lane serial receiver. It runs on the link clock. A free-running counter advances once per link cycle and wraps after a programmable number of counts, so each wrap marks the start of a local multiframe. A system reference strobe re-phases that counter. The strobe is first registered, and a fixed two-cycle pipeline then forces the counter to zero. The delay is the same on every power-up, which is what gives the link its deterministic latency.

The block drives three outputs: the current count, a boundary flag that is high while the count is zero, and an active-low synchronization request toward the transmitter. The request is released only on a multiframe boundary. Logic further down the receiver raises a "link ready" request whenever it is prepared to leave code-group synchronization. The block holds the request low until the next boundary and releases it there.

Top module: `mf_phase_gen`

## Requirements
- R1: The SYSREF input is registered on the link clock. Let k be the rising edge at which that register first captures a high value. The count reads 0 after rising edge k+2, whatever phase it had before.
- R2: Except when a re-phase is being applied, the count goes up by exactly one on each link clock edge while it is below the wrap value.
- R3: The count wraps to 0 on the edge after it reaches `wrap_val`. The multiframe length is `wrap_val`+1 counts, for any `wrap_val` from 0 to 31. If `wrap_val` is lowered below the current count, the next edge also returns the count to 0.
- R4: A SYSREF that stays high for several cycles re-phases the counter only once, at its rising edge. The rest of the high time has no effect on the count.
- R5: `mf_edge` is 1 exactly in the cycles where `mf_count` is 0.
- R6: `sync_n` goes from 0 to 1 only in a cycle where `mf_edge` is 1. If `link_rdy` is raised mid-multiframe, `sync_n` stays 0 until the count next reaches 0 and goes high in that same cycle. After that it stays 1 while `link_rdy` stays 1.
- R7: If `link_rdy` is 0 at a clock edge, `sync_n` is 0 after that edge.
- R8: A synchronous active-high reset sets `mf_count` to 0 and `sync_n` to 0. It also clears the SYSREF pipeline, so no re-phase is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| sysref_in | input | 1 | System reference strobe, sampled on clk |
| wrap_val | input | 5 | Last count value of a multiframe (length minus one) |
| link_rdy | input | 1 | Request to release the synchronization request |
| mf_count | output | 5 | Current position inside the local multiframe |
| mf_edge | output | 1 | High while the count is zero (multiframe boundary) |
| sync_n | output | 1 | Active-low synchronization request, released on a boundary |

## Verification
The hardest case to reach from the ports is a SYSREF that lands while the counter is at an arbitrary phase or is held high for many cycles. The stimulus therefore follows each strobe with a different number of idle cycles and uses several wrap values, including a length of one and a length of thirty-two. Each expected count is the idle-cycle distance from the re-phase point, reduced modulo the length, so an error in the delay or a repeated re-phase shows up as a wrong count. The release of the synchronization request is tested with `link_rdy` raised in mid-multiframe and again in the very cycle before a wrap.

// File: rtl/mf_phase_pkg.sv
package mf_phase_pkg;

    // Registered SYSREF pipeline: sample, previous sample, pending re-phase
    typedef struct packed {
        logic samp;
        logic prev;
        logic pend;
    } sref_pipe_t;

    typedef enum logic {
        SYNC_REQ  = 1'b0,
        SYNC_DONE = 1'b1
    } sync_state_t;

    function automatic logic rise_seen(input sref_pipe_t p);
        return p.samp & ~p.prev;
    endfunction

endpackage

// File: rtl/sref_capture.sv
module sref_capture
    import mf_phase_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sysref_in,
    output logic realign
);
    sref_pipe_t pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe.samp <= sysref_in;
            pipe.prev <= pipe.samp;
            pipe.pend <= rise_seen(pipe);
        end
    end

    assign realign = pipe.pend;
endmodule

// File: rtl/mf_counter.sv
module mf_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             realign,
    input  logic [CNT_W-1:0] wrap_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        if (realign)
            count_nxt = '0;
        else if (count >= wrap_val)
            count_nxt = '0;
        else
            count_nxt = count + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nxt;
    end
endmodule

// File: rtl/sync_gate.sv
module sync_gate
    import mf_phase_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_rdy,
    input  logic [CNT_W-1:0] count_nxt,
    output logic             sync_n
);
    sync_state_t state;

    always_ff @(posedge clk) begin
        if (rst)
            state <= SYNC_REQ;
        else if (!link_rdy)
            state <= SYNC_REQ;
        else if (count_nxt == '0)
            state <= SYNC_DONE;
    end

    assign sync_n = (state == SYNC_DONE);
endmodule

// File: rtl/mf_phase_gen.sv
module mf_phase_gen #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sysref_in,
    input  logic [CNT_W-1:0] wrap_val,
    input  logic             link_rdy,
    output logic [CNT_W-1:0] mf_count,
    output logic             mf_edge,
    output logic             sync_n
);
    logic             realign;
    logic [CNT_W-1:0] count_nxt;

    sref_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .sysref_in (sysref_in),
        .realign   (realign)
    );

    mf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .wrap_val  (wrap_val),
        .count     (mf_count),
        .count_nxt (count_nxt)
    );

    sync_gate #(.CNT_W(CNT_W)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .link_rdy  (link_rdy),
        .count_nxt (count_nxt),
        .sync_n    (sync_n)
    );

    assign mf_edge = (mf_count == '0);
endmodule

// File: rtl/mf_phase_chk.sv
module mf_phase_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sysref_in,
    input logic [CNT_W-1:0] wrap_val,
    input logic             link_rdy,
    input logic [CNT_W-1:0] mf_count,
    input logic             mf_edge,
    input logic             sync_n,
    input logic             realign
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1: zero count three sampled edges after a port-level rising edge
    a_r1_rephase_delay: assert property (@(posedge clk) disable iff (rst)
        (sysref_in && !$past(sysref_in)) |-> ##3 (mf_count == '0));

    // R2: single step when not re-phasing and below wrap
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!realign && mf_count < wrap_val) |=> (mf_count == $past(mf_count) + ONE));

    // R3: wrap to zero at or above wrap value
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (mf_count >= wrap_val) |=> (mf_count == '0));

    // R4: a re-phase request never lasts two cycles
    a_r4_single_rephase: assert property (@(posedge clk) disable iff (rst)
        realign |=> !realign);

    // R5: boundary flag tracks zero count
    a_r5_edge_flag: assert property (@(posedge clk) disable iff (rst)
        mf_edge == (mf_count == '0));

    // R6: release only on a boundary
    a_r6_release_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> mf_edge);

    // R7: dropping the ready request re-asserts the sync request
    a_r7_drop: assert property (@(posedge clk) disable iff (rst)
        !link_rdy |=> !sync_n);

    // R8: reset state
    a_r8_reset: assert property (@(posedge clk)
        rst |=> (mf_count == '0 && !sync_n));
endmodule

bind mf_phase_gen mf_phase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sysref_in (sysref_in),
    .wrap_val  (wrap_val),
    .link_rdy  (link_rdy),
    .mf_count  (mf_count),
    .mf_edge   (mf_edge),
    .sync_n    (sync_n),
    .realign   (realign)
);

// File: tb/sim_mf_phase_gen.sv
`timescale 1ns/1ps
module sim_mf_phase_gen;
    localparam int CNT_W = 5;
    localparam int NV    = 8;
    // each row: wrap value, SYSREF high cycles, idle cycles after re-phase
    localparam int VEC [NV][3] = '{
        '{7, 1, 0}, '{7, 1, 5}, '{7, 1, 11}, '{7, 6, 10},
        '{0, 1, 5}, '{31, 1, 40}, '{4, 3, 9}, '{2, 2, 2}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sysref_in = 1'b0;
    logic [CNT_W-1:0] wrap_val = 5'd7;
    logic             link_rdy = 1'b0;
    logic [CNT_W-1:0] mf_count;
    logic             mf_edge;
    logic             sync_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mf_phase_gen #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .sysref_in(sysref_in), .wrap_val(wrap_val),
        .link_rdy(link_rdy), .mf_count(mf_count), .mf_edge(mf_edge), .sync_n(sync_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // pulse SYSREF for 'hold' cycles, then stop at the negedge after edge k+2+idle
    task automatic rephase(input int hold, input int idle);
        @(negedge clk);
        sysref_in = 1'b1;
        for (int i = 0; i < 3 + idle; i++) begin
            step();
            if (i + 1 == hold) sysref_in = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) step();
        chk("R8 count in reset", mf_count, 0);
        chk("R8 sync_n in reset", sync_n, 0);
        rst = 1'b0;
        repeat (3) step();

        // table walk: R1 delay, R3 wrap length, R4 held strobe, R5 flag
        for (int v = 0; v < NV; v++) begin
            int exp_cnt;
            wrap_val = VEC[v][0][CNT_W-1:0];
            repeat (2) step();
            rephase(VEC[v][1], VEC[v][2]);
            exp_cnt = VEC[v][2] % (VEC[v][0] + 1);
            if (VEC[v][1] > 1)
                chk($sformatf("R4 held strobe row %0d", v), mf_count, exp_cnt);
            else
                chk($sformatf("R1/R3 count row %0d", v), mf_count, exp_cnt);
            chk($sformatf("R5 flag row %0d", v), mf_edge, exp_cnt == 0);
        end

        // R2: counting after re-phase, wrap 7
        wrap_val = 5'd7;
        link_rdy = 1'b0;
        rephase(1, 0);
        chk("R1 zero after re-phase", mf_count, 0);
        for (int s = 1; s <= 3; s++) begin
            step();
            chk("R2 increment", mf_count, s);
        end

        // R6: ready raised mid-multiframe waits for the boundary
        link_rdy = 1'b1;
        for (int s = 4; s <= 7; s++) begin
            step();
            chk("R6 held low mid-frame", sync_n, 0);
            chk("R2 increment late", mf_count, s);
        end
        step();
        chk("R6 released on boundary", sync_n, 1);
        chk("R5 flag at boundary", mf_edge, 1);
        step();
        chk("R6 stays released", sync_n, 1);
        chk("R5 flag off mid-frame", mf_edge, 0);

        // R7: drop ready
        link_rdy = 1'b0;
        step();
        chk("R7 sync re-asserted", sync_n, 0);
        // count now 2; walk to the wrap value
        for (int s = 3; s <= 7; s++) begin
            step();
            chk("R7 stays low", sync_n, 0);
        end
        chk("R3 at wrap value", mf_count, 7);
        link_rdy = 1'b1;
        step();
        chk("R6 ready just before wrap", sync_n, 1);
        chk("R3 wrapped", mf_count, 0);

        // R3: lowering wrap below current count
        repeat (5) step();
        wrap_val = 5'd2;
        step();
        chk("R3 shrink wrap", mf_count, 0);

        // R8: reset mid-run
        repeat (2) step();
        rst = 1'b1;
        step();
        chk("R8 count after reset", mf_count, 0);
        chk("R8 sync_n after reset", sync_n, 0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule